// File: doc/BRIEF.md
# Victim Line Buffer

The block is a small, fully associative side store placed beside a direct-mapped first-level cache. Lines that the first-level cache throws out on replacement are parked here, so a later conflict miss on the same block can be served from this buffer instead of from the next memory level. Every stored entry carries a valid flag, the full block tag (first-level tag together with its line index), the line data and a dirty flag. Lookups are only presented on first-level misses, so the first-level hit path sees no extra delay.

A lookup compares its block tag against every entry at once. On a hit, the stored line and its dirty flag go back to the first-level cache one cycle later. If a first-level eviction comes in the same cycle, the evicted line takes over the freed slot, so the two lines swap places. On a miss, a request for the block goes to the next level one cycle later, and any eviction in that cycle is placed in the oldest slot in first-in first-out order. A dirty line pushed out of that slot is sent to the next level as a write-back in the same following cycle.

Top module: `victim_buf`

## Requirements
- R1: After reset every output is low and the buffer holds no line, so the first lookup misses.
- R2: A lookup whose tag matches a valid entry raises `fill_valid` in the next cycle, with that entry's data on `fill_data` and its dirty flag on `fill_dirty`, and leaves `nl_req_valid` low.
- R3: A lookup that matches no valid entry raises `nl_req_valid` in the next cycle with `nl_req_tag` equal to the lookup tag, and leaves `fill_valid` low.
- R4: A hitting lookup with an eviction in the same cycle swaps the lines. The evicted line (tag, data, dirty) sits in the hit slot, and the returned line is no longer held.
- R5: A hitting lookup with no eviction in the same cycle removes the returned line from the buffer.
- R6: An eviction with no lookup, or with a missing lookup, is stored. Up to `ENTRIES` evicted lines stay retrievable at once.
- R7: An insertion goes into a round-robin slot, so once the buffer is full the line inserted earliest is the one overwritten. A swap does not move the insertion slot.
- R8: When an insertion overwrites a valid dirty entry, `wb_valid` is high in the next cycle with that entry's tag on `wb_tag` and data on `wb_data`. When the overwritten entry is clean or empty, `wb_valid` stays low.
- R9: `fill_valid` and `nl_req_valid` are never high in the same cycle.
- R10: In a cycle after one with no lookup, `fill_valid` and `nl_req_valid` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_valid | input | 1 | Lookup strobe, presented on a first-level miss |
| lkp_tag | input | BLK_W | Block tag of the lookup |
| ev_valid | input | 1 | First-level eviction strobe |
| ev_tag | input | BLK_W | Block tag of the evicted line |
| ev_data | input | LINE_W | Data of the evicted line |
| ev_dirty | input | 1 | Evicted line is modified |
| fill_valid | output | 1 | Line returned to the first-level cache |
| fill_data | output | LINE_W | Returned line data |
| fill_dirty | output | 1 | Returned line is modified |
| nl_req_valid | output | 1 | Fetch request to the next level |
| nl_req_tag | output | BLK_W | Block tag to fetch |
| wb_valid | output | 1 | Write-back of a displaced dirty line |
| wb_tag | output | BLK_W | Block tag of the write-back |
| wb_data | output | LINE_W | Data of the write-back |

## Verification
Two things can land in one cycle: a lookup and the insertion of a first-level eviction. The bench drives both strobes together in two cases. In the first the lookup hits, and the bench expects a swap: the returned line matches what was stored, a later lookup of the evicted tag returns its data and dirty flag, and the old tag then misses. In the second the lookup misses while the oldest slot holds a dirty line, and the bench expects a fetch request and a write-back of the displaced line in the same following cycle. It then confirms that the next-oldest line is still present.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // Action taken on the entry store in one cycle
  typedef enum logic [1:0] {
    VB_IDLE   = 2'd0,
    VB_SWAP   = 2'd1,  // hit with eviction: overwrite hit slot
    VB_TAKE   = 2'd2,  // hit without eviction: release hit slot
    VB_INSERT = 2'd3   // eviction into round-robin slot
  } vb_act_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ENTRIES = 8,
  parameter int BLK_W   = 16,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0]            valid_q,
  input  logic [ENTRIES-1:0][BLK_W-1:0] tag_q,
  input  logic [BLK_W-1:0]              key,
  output logic                          hit,
  output logic [IW-1:0]                 hit_idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = hit_idx | IW'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/vb_store.sv
module vb_store #(
  parameter int ENTRIES = 8,
  parameter int BLK_W   = 16,
  parameter int LINE_W  = 32,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IW-1:0]                  wr_idx,
  input  logic [BLK_W-1:0]               wr_tag,
  input  logic [LINE_W-1:0]              wr_data,
  input  logic                           wr_dirty,
  input  logic                           clr_en,
  input  logic [IW-1:0]                  clr_idx,
  output logic [ENTRIES-1:0]             valid_q,
  output logic [ENTRIES-1:0]             dirty_q,
  output logic [ENTRIES-1:0][BLK_W-1:0]  tag_q,
  output logic [ENTRIES-1:0][LINE_W-1:0] data_q
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic we, ce, valid_d;

    always_comb begin
      we      = wr_en  && (wr_idx  == IW'(g));
      ce      = clr_en && (clr_idx == IW'(g));
      valid_d = valid_q[g];
      if (ce) valid_d = 1'b0;
      if (we) valid_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else begin
        valid_q[g] <= valid_d;
        if (we) begin
          dirty_q[g] <= wr_dirty;
          tag_q[g]   <= wr_tag;
          data_q[g]  <= wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/victim_buf.sv
module victim_buf #(
  parameter int ENTRIES = 8,
  parameter int BLK_W   = 16,
  parameter int LINE_W  = 32,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [BLK_W-1:0]  lkp_tag,
  input  logic              ev_valid,
  input  logic [BLK_W-1:0]  ev_tag,
  input  logic [LINE_W-1:0] ev_data,
  input  logic              ev_dirty,
  output logic              fill_valid,
  output logic [LINE_W-1:0] fill_data,
  output logic              fill_dirty,
  output logic              nl_req_valid,
  output logic [BLK_W-1:0]  nl_req_tag,
  output logic              wb_valid,
  output logic [BLK_W-1:0]  wb_tag,
  output logic [LINE_W-1:0] wb_data
);
  import vb_pkg::*;

  logic [ENTRIES-1:0]             valid_q, dirty_q;
  logic [ENTRIES-1:0][BLK_W-1:0]  tag_q;
  logic [ENTRIES-1:0][LINE_W-1:0] data_q;
  logic                           m_hit;
  logic [IW-1:0]                  m_idx;
  logic [IW-1:0]                  ptr_q, ptr_d;
  vb_act_e                        act;
  logic                           wr_en, clr_en;
  logic [IW-1:0]                  wr_idx;

  // next-state values of the output registers
  logic              fill_v_d, fill_dirty_d, req_v_d, wb_v_d;
  logic [LINE_W-1:0] fill_data_d, wb_data_d;
  logic [BLK_W-1:0]  wb_tag_d;

  vb_match #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_match (
    .valid_q (valid_q),
    .tag_q   (tag_q),
    .key     (lkp_tag),
    .hit     (m_hit),
    .hit_idx (m_idx)
  );

  vb_store #(.ENTRIES(ENTRIES), .BLK_W(BLK_W), .LINE_W(LINE_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (ev_tag),
    .wr_data  (ev_data),
    .wr_dirty (ev_dirty),
    .clr_en   (clr_en),
    .clr_idx  (m_idx),
    .valid_q  (valid_q),
    .dirty_q  (dirty_q),
    .tag_q    (tag_q),
    .data_q   (data_q)
  );

  always_comb begin
    if (lkp_valid && m_hit) act = ev_valid ? VB_SWAP : VB_TAKE;
    else if (ev_valid)      act = VB_INSERT;
    else                    act = VB_IDLE;
  end

  always_comb begin
    wr_en        = (act == VB_SWAP) || (act == VB_INSERT);
    clr_en       = (act == VB_TAKE);
    wr_idx       = (act == VB_SWAP) ? m_idx : ptr_q;
    ptr_d        = ptr_q;
    if (act == VB_INSERT)
      ptr_d = (ptr_q == IW'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    fill_v_d     = lkp_valid && m_hit;
    fill_data_d  = data_q[m_idx];
    fill_dirty_d = dirty_q[m_idx];
    req_v_d      = lkp_valid && !m_hit;
    wb_v_d       = (act == VB_INSERT) && valid_q[ptr_q] && dirty_q[ptr_q];
    wb_tag_d     = tag_q[ptr_q];
    wb_data_d    = data_q[ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q        <= '0;
      fill_valid   <= 1'b0;
      fill_data    <= '0;
      fill_dirty   <= 1'b0;
      nl_req_valid <= 1'b0;
      nl_req_tag   <= '0;
      wb_valid     <= 1'b0;
      wb_tag       <= '0;
      wb_data      <= '0;
    end else begin
      ptr_q        <= ptr_d;
      fill_valid   <= fill_v_d;
      nl_req_valid <= req_v_d;
      wb_valid     <= wb_v_d;
      if (fill_v_d) begin
        fill_data  <= fill_data_d;
        fill_dirty <= fill_dirty_d;
      end
      if (req_v_d) nl_req_tag <= lkp_tag;
      if (wb_v_d) begin
        wb_tag  <= wb_tag_d;
        wb_data <= wb_data_d;
      end
    end
  end
endmodule

// File: rtl/vb_chk.sv
module vb_chk #(
  parameter int BLK_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lkp_valid,
  input logic [BLK_W-1:0] lkp_tag,
  input logic             ev_valid,
  input logic             fill_valid,
  input logic             nl_req_valid,
  input logic [BLK_W-1:0] nl_req_tag,
  input logic             wb_valid
);
  // R9
  fill_req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && nl_req_valid));

  // R2
  lookup_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> (fill_valid || nl_req_valid));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> (!fill_valid && !nl_req_valid));

  // R3
  req_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid ##1 nl_req_valid) |-> (nl_req_tag == $past(lkp_tag)));

  // R8
  wb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !wb_valid);
endmodule

bind victim_buf vb_chk #(.BLK_W(BLK_W)) u_vb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lkp_valid    (lkp_valid),
  .lkp_tag      (lkp_tag),
  .ev_valid     (ev_valid),
  .fill_valid   (fill_valid),
  .nl_req_valid (nl_req_valid),
  .nl_req_tag   (nl_req_tag),
  .wb_valid     (wb_valid)
);

// File: tb/victim_buf_test.sv
`timescale 1ns/1ps
module victim_buf_test;
  localparam int ENTRIES = 8;
  localparam int BLK_W   = 16;
  localparam int LINE_W  = 32;

  logic              clk, rst_n;
  logic              lkp_valid, ev_valid, ev_dirty;
  logic [BLK_W-1:0]  lkp_tag, ev_tag;
  logic [LINE_W-1:0] ev_data;
  logic              fill_valid, fill_dirty, nl_req_valid, wb_valid;
  logic [LINE_W-1:0] fill_data, wb_data;
  logic [BLK_W-1:0]  nl_req_tag, wb_tag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  victim_buf #(.ENTRIES(ENTRIES), .BLK_W(BLK_W), .LINE_W(LINE_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_tag(lkp_tag),
    .ev_valid(ev_valid), .ev_tag(ev_tag), .ev_data(ev_data), .ev_dirty(ev_dirty),
    .fill_valid(fill_valid), .fill_data(fill_data), .fill_dirty(fill_dirty),
    .nl_req_valid(nl_req_valid), .nl_req_tag(nl_req_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // memory model: line contents derived from the block tag
  function automatic logic [LINE_W-1:0] mem_line(input logic [BLK_W-1:0] t);
    return {t ^ 16'h5A5A, ~t};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus; outputs are sampled at the next falling edge
  task automatic step(input logic lv, input logic [BLK_W-1:0] lt,
                      input logic ev, input logic [BLK_W-1:0] et, input logic ed);
    lkp_valid = lv; lkp_tag = lt;
    ev_valid = ev; ev_tag = et; ev_data = mem_line(et); ev_dirty = ed;
    @(negedge clk);
    lkp_valid = 1'b0; ev_valid = 1'b0;
    check("R9", "fill and request together", 64'(fill_valid && nl_req_valid), 64'd0);
  endtask

  task automatic expect_hit(input string req, input logic [BLK_W-1:0] t, input logic d);
    check(req, "fill_valid", 64'(fill_valid), 64'd1);
    check(req, "fill_data", 64'(fill_data), 64'(mem_line(t)));
    check(req, "fill_dirty", 64'(fill_dirty), 64'(d));
    check(req, "nl_req_valid on hit", 64'(nl_req_valid), 64'd0);
  endtask

  task automatic expect_miss(input string req, input logic [BLK_W-1:0] t);
    check(req, "nl_req_valid", 64'(nl_req_valid), 64'd1);
    check(req, "nl_req_tag", 64'(nl_req_tag), 64'(t));
    check(req, "fill_valid on miss", 64'(fill_valid), 64'd0);
  endtask

  task automatic t_reset;
    check("R1", "fill_valid", 64'(fill_valid), 64'd0);
    check("R1", "nl_req_valid", 64'(nl_req_valid), 64'd0);
    check("R1", "wb_valid", 64'(wb_valid), 64'd0);
    step(1'b1, 16'h0005, 1'b0, '0, 1'b0);
    expect_miss("R1", 16'h0005);
  endtask

  task automatic t_fill_all;  // R6: eight inserts into an empty buffer
    for (int i = 0; i < ENTRIES; i++) begin
      step(1'b0, '0, 1'b1, 16'h0100 + 16'(i), 1'(i % 2));
      check("R8", "no write-back into empty slot", 64'(wb_valid), 64'd0);
    end
    step(1'b0, '0, 1'b0, '0, 1'b0);
    check("R10", "idle fill_valid", 64'(fill_valid), 64'd0);
    check("R10", "idle nl_req_valid", 64'(nl_req_valid), 64'd0);
  endtask

  task automatic t_swap;  // R4, R2, R5
    step(1'b1, 16'h0103, 1'b1, 16'h0200, 1'b1);
    expect_hit("R2", 16'h0103, 1'b1);
    check("R4", "no write-back on swap", 64'(wb_valid), 64'd0);
    step(1'b1, 16'h0200, 1'b0, '0, 1'b0);
    expect_hit("R4", 16'h0200, 1'b1);
    step(1'b1, 16'h0200, 1'b0, '0, 1'b0);
    expect_miss("R5", 16'h0200);
    step(1'b1, 16'h0103, 1'b0, '0, 1'b0);
    expect_miss("R4", 16'h0103);
  endtask

  task automatic t_replace;  // R7, R8, R3
    // round-robin slot is back at the first inserted line (0x100, clean)
    step(1'b0, '0, 1'b1, 16'h0300, 1'b0);
    check("R8", "clean overwrite no write-back", 64'(wb_valid), 64'd0);
    // miss together with insertion over 0x101 (dirty)
    step(1'b1, 16'h0100, 1'b1, 16'h0301, 1'b1);
    expect_miss("R7", 16'h0100);
    check("R8", "wb_valid", 64'(wb_valid), 64'd1);
    check("R8", "wb_tag", 64'(wb_tag), 64'h0101);
    check("R8", "wb_data", 64'(wb_data), 64'(mem_line(16'h0101)));
    step(1'b1, 16'h0101, 1'b0, '0, 1'b0);
    expect_miss("R7", 16'h0101);
    step(1'b1, 16'h0102, 1'b0, '0, 1'b0);
    expect_hit("R7", 16'h0102, 1'b0);
    step(1'b1, 16'h0301, 1'b0, '0, 1'b0);
    expect_hit("R6", 16'h0301, 1'b1);
    step(1'b1, 16'h0107, 1'b0, '0, 1'b0);
    expect_hit("R6", 16'h0107, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    lkp_valid = 1'b0; lkp_tag = '0;
    ev_valid = 1'b0; ev_tag = '0; ev_data = '0; ev_dirty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_fill_all;
    t_swap;
    t_replace;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule